// File: doc/BRIEF.md
# SAR ADC Conversion-and-Read Controller

This block is the host side of a link to a 14-bit successive-approximation converter that has a 3-wire serial port and no busy flag. The convert line also acts as the chip select. When a start request arrives, the controller raises the convert line and keeps it high for a fixed number of system clocks. That count covers the converter's longest conversion, so the converter never drives a busy flag. The controller then drops the convert line, which makes the converter put its most significant bit on the data line with no clock edge. The controller reads that bit first and then reads 13 more bits with 13 serial clock pulses.

The controller puts the 14-bit word on a parallel output and marks it with a one-cycle valid strobe. A quiet interval follows before the next conversion can start. The conversion hold time, the serial clock half-period and the quiet time are parameters, all counted in system clocks.

The state machine has five states. IDLE waits for a request, and the transition IDLE->CONVERT happens on `start`. CONVERT drives the convert line high, and the transition CONVERT->LEAD happens when the hold count ends. LEAD drives the convert line low, waits half a serial clock period and samples the MSB; the transition LEAD->SHIFT happens after that sample. SHIFT makes 13 serial clock pulses, each with the high half first, and samples one bit at the end of each low half. The transition SHIFT->QUIET happens after the last sample, which also loads the result and sends the strobe. QUIET waits out the idle gap, and the transition QUIET->IDLE happens when the gap count ends.

Top module: `sar_read_ctrl`

## Requirements
- R1: While reset is held and just after it ends, `cnv` and `sck` are 0, `result_valid` is 0 and `result` is zero.
- R2: A `start` seen in IDLE raises `cnv` at the next clock edge. `cnv` then stays high for exactly TCONV_MAX_CYCLES clocks before it falls.
- R3: `sck` is 0 whenever `cnv` is high and whenever no read is in progress.
- R4: Each read makes exactly DATA_W-1 (13) pulses on `sck`. Each pulse is high for SCK_HALF_CYCLES clocks and then low for SCK_HALF_CYCLES clocks.
- R5: The MSB on `adc_dout` is sampled SCK_HALF_CYCLES clocks after `cnv` falls. Each later bit is sampled SCK_HALF_CYCLES clocks after a falling edge of `sck`. The bits fill `result` MSB first, so `result[13]` is the first bit read.
- R6: `result_valid` is high for one clock only. It goes high TCONV_MAX_CYCLES + 27*SCK_HALF_CYCLES clock edges after the edge that accepted `start`. `result` keeps its value until the next read completes.
- R7: A `start` seen in any state other than IDLE (CONVERT, LEAD, SHIFT, QUIET) has no effect: no extra conversion and no extra strobe.
- R8: After `result_valid` rises, `cnv` stays low. With `start` held high, the next rise of `cnv` comes exactly TQUIET_CYCLES+1 clocks after `result_valid` rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one conversion and read |
| adc_dout | input | 1 | Serial data from the converter |
| cnv | output | 1 | Convert line, also the chip select |
| sck | output | 1 | Serial clock to the converter |
| result | output | DATA_W | Last word read, MSB first |
| result_valid | output | 1 | One-cycle strobe when `result` updates |

## Verification
The embedded assertions check these on every cycle:
- the convert pulse width;
- that the serial clock stays low while the convert line is high;
- that exactly 13 clock pulses come before each strobe;
- that the strobe lasts one cycle;
- that a conversion starts only from IDLE.

Only the bench scenarios can show these:
- that the bits are put together in the right order for several data patterns, with a behavioural converter model driving the data line;
- the exact start-to-strobe latency;
- the quiet gap before a back-to-back conversion;
- that repeated requests during a read are dropped.

// File: rtl/sar_read_pkg.sv
package sar_read_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONVERT,
        ST_LEAD,
        ST_SHIFT,
        ST_QUIET
    } rd_state_t;
endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     count <= '0;
        else if (clear) count <= '0;
        else            count <= count + 1'b1;
    end
endmodule

// File: rtl/ser_capture.sv
module ser_capture #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        word <= '0;
        else if (shift_en) word <= {word[W-2:0], din};
    end
endmodule

// File: rtl/sar_read_ctrl.sv
module sar_read_ctrl
    import sar_read_pkg::*;
#(
    parameter int DATA_W           = 14,
    parameter int TCONV_MAX_CYCLES = 40,
    parameter int SCK_HALF_CYCLES  = 2,
    parameter int TQUIET_CYCLES    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              adc_dout,
    output logic              cnv,
    output logic              sck,
    output logic [DATA_W-1:0] result,
    output logic              result_valid
);
    localparam int TMAX = (TCONV_MAX_CYCLES > SCK_HALF_CYCLES) ?
                          ((TCONV_MAX_CYCLES > TQUIET_CYCLES) ? TCONV_MAX_CYCLES : TQUIET_CYCLES) :
                          ((SCK_HALF_CYCLES > TQUIET_CYCLES) ? SCK_HALF_CYCLES : TQUIET_CYCLES);
    localparam int TW   = $clog2(TMAX + 1);
    localparam int BW   = $clog2(DATA_W);
    localparam logic [TW-1:0] T_CONV_END  = TW'(TCONV_MAX_CYCLES - 1);
    localparam logic [TW-1:0] T_HALF_END  = TW'(SCK_HALF_CYCLES - 1);
    localparam logic [TW-1:0] T_QUIET_END = TW'(TQUIET_CYCLES - 1);
    localparam logic [BW-1:0] LAST_BIT    = BW'(DATA_W - 2);

    rd_state_t         state_q, state_d;
    logic [TW-1:0]     tmr;
    logic              tmr_clear;
    logic              sck_hi_q, sck_hi_d;
    logic [BW-1:0]     bits_q, bits_d;
    logic              sample_en, last_sample;
    logic [DATA_W-1:0] cap_word;

    phase_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(tmr_clear), .count(tmr)
    );

    ser_capture #(.W(DATA_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .shift_en(sample_en), .din(adc_dout), .word(cap_word)
    );

    // next state and sequencing
    always_comb begin
        state_d     = state_q;
        tmr_clear   = 1'b0;
        sck_hi_d    = sck_hi_q;
        bits_d      = bits_q;
        sample_en   = 1'b0;
        last_sample = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                tmr_clear = 1'b1;
                if (start) state_d = ST_CONVERT;
            end
            ST_CONVERT: begin
                if (tmr == T_CONV_END) begin
                    state_d   = ST_LEAD;
                    tmr_clear = 1'b1;
                end
            end
            ST_LEAD: begin
                if (tmr == T_HALF_END) begin
                    state_d   = ST_SHIFT;
                    tmr_clear = 1'b1;
                    sample_en = 1'b1;
                    sck_hi_d  = 1'b1;
                    bits_d    = '0;
                end
            end
            ST_SHIFT: begin
                if (tmr == T_HALF_END) begin
                    tmr_clear = 1'b1;
                    sck_hi_d  = ~sck_hi_q;
                    if (!sck_hi_q) begin
                        sample_en = 1'b1;
                        if (bits_q == LAST_BIT) begin
                            last_sample = 1'b1;
                            state_d     = ST_QUIET;
                        end else begin
                            bits_d = bits_q + 1'b1;
                        end
                    end
                end
            end
            ST_QUIET: begin
                if (tmr == T_QUIET_END) begin
                    state_d   = ST_IDLE;
                    tmr_clear = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            sck_hi_q     <= 1'b0;
            bits_q       <= '0;
            result       <= '0;
            result_valid <= 1'b0;
        end else begin
            state_q      <= state_d;
            sck_hi_q     <= sck_hi_d;
            bits_q       <= bits_d;
            result_valid <= last_sample;
            if (last_sample) result <= {cap_word[DATA_W-2:0], adc_dout};
        end
    end

    // outputs
    always_comb begin
        cnv = 1'b0;
        sck = 1'b0;
        unique case (state_q)
            ST_CONVERT: cnv = 1'b1;
            ST_SHIFT:   sck = sck_hi_q;
            default: begin
                cnv = 1'b0;
                sck = 1'b0;
            end
        endcase
    end

    // checking counters
    logic [15:0] cnv_run;
    logic [7:0]  sck_rises;
    logic        sck_prev;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnv_run   <= '0;
            sck_rises <= '0;
            sck_prev  <= 1'b0;
        end else begin
            sck_prev  <= sck;
            cnv_run   <= cnv ? cnv_run + 1'b1 : '0;
            if (cnv)                  sck_rises <= '0;
            else if (sck && !sck_prev) sck_rises <= sck_rises + 1'b1;
        end
    end

    AST_CNV_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnv) |-> cnv_run == 16'(TCONV_MAX_CYCLES)); // R2
    AST_SCK_LOW_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        cnv |-> !sck); // R3
    AST_SCK_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> sck_rises == 8'(DATA_W - 1)); // R4
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid); // R6
    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv) |-> $past(state_q) == ST_IDLE); // R7
endmodule

// File: tb/sar_read_ctrl_bench.sv
module sar_read_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW   = 14;
    localparam int TC   = 20;
    localparam int HALF = 2;
    localparam int TQ   = 5;
    localparam int NVEC = 6;
    localparam logic [DW-1:0] VEC [NVEC] = '{14'h0000, 14'h3FFF, 14'h2AAA,
                                             14'h1555, 14'h2001, 14'h0001};

    logic clk = 0, rst_n = 0, start = 0, adc_dout = 0;
    logic cnv, sck, result_valid;
    logic [DW-1:0] result;
    int n_checks = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sar_read_ctrl #(.DATA_W(DW), .TCONV_MAX_CYCLES(TC), .SCK_HALF_CYCLES(HALF),
                    .TQUIET_CYCLES(TQ)) u_sar_read_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .adc_dout(adc_dout),
        .cnv(cnv), .sck(sck), .result(result), .result_valid(result_valid));

    // behavioural converter
    logic [DW-1:0] adc_next = '0, adc_word = '0;
    int adc_idx = 0;
    int cnv_rises = 0, sck_pulses = 0, valid_cnt = 0;
    always @(posedge cnv) begin
        adc_word <= adc_next; cnv_rises++; sck_pulses = 0;
    end
    always @(negedge cnv) begin
        adc_idx = DW - 1; adc_dout <= adc_word[DW-1];
    end
    always @(negedge sck) if (!cnv && adc_idx > 0) begin
        adc_idx--; adc_dout <= adc_word[adc_idx];
    end
    always @(posedge sck) begin
        sck_pulses++;
        if (cnv) begin
            n_checks++; n_fail++;
            $display("FAIL R3 sck rose while cnv high act=1 exp=0");
        end
    end
    always @(posedge clk) if (rst_n && result_valid) valid_cnt++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // issue one start, return latency (negedges) to valid and cnv high width
    task automatic run_one(input logic [DW-1:0] w, output int lat, output int cw);
        adc_next = w;
        @(negedge clk); start = 1; lat = 0; cw = 0;
        do begin
            @(negedge clk); start = 0; lat++;
            if (cnv) cw++;
        end while (!result_valid && lat < 2000);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired act=1 exp=0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int lat, cw, v0, r0, gap;
        repeat (3) @(negedge clk);
        check(cnv == 0 && sck == 0, "R1 cnv/sck in reset", {cnv, sck}, 0);
        rst_n = 1;
        @(negedge clk);
        check(result_valid == 0 && result == 0, "R1 outputs after reset", result, 0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            int p0;
            p0 = sck_pulses;
            run_one(VEC[i], lat, cw);
            check(result == VEC[i], "R5 captured word", result, VEC[i]);
            check(cw == TC, "R2 cnv high width", cw, TC);
            check(sck_pulses == DW - 1, "R4 sck pulse count", sck_pulses, DW - 1);
            check(lat == TC + 27 * HALF + 1, "R6 start to valid latency", lat, TC + 27 * HALF + 1);
            @(negedge clk);
            check(result_valid == 0, "R6 valid one cycle", result_valid, 0);
            check(result == VEC[i], "R6 result held", result, VEC[i]);
            check(sck == 0 && cnv == 0, "R3 idle sck low", sck, 0);
            repeat (TQ + 2) @(negedge clk);
        end

        // R4 pulse shape: measure high time of one pulse
        adc_next = 14'h0F0F;
        @(negedge clk); start = 1; @(negedge clk); start = 0;
        wait (sck == 1);
        @(negedge clk);
        begin
            int hi = 0, lo = 0;
            while (sck) begin hi++; @(negedge clk); end
            while (!sck && !result_valid && lo < 100) begin lo++; @(negedge clk); end
            check(hi == HALF - 1 || hi == HALF, "R4 sck high half", hi, HALF);
            check(lo == HALF, "R4 sck low half", lo, HALF);
        end
        wait (result_valid); @(negedge clk);
        check(result == 14'h0F0F, "R5 word 0F0F", result, 14'h0F0F);
        repeat (TQ + 2) @(negedge clk);

        // R7: extra starts during conversion, read and quiet are dropped
        r0 = cnv_rises; v0 = valid_cnt;
        adc_next = 14'h1234;
        @(negedge clk); start = 1; @(negedge clk); start = 0;
        repeat (5) @(negedge clk); start = 1; @(negedge clk); start = 0;
        wait (sck == 1); @(negedge clk); start = 1; @(negedge clk); start = 0;
        wait (result_valid); @(negedge clk); start = 1; @(negedge clk); start = 0;
        repeat (TC + 30 * HALF + TQ) @(negedge clk);
        check(cnv_rises - r0 == 1, "R7 conversions launched", cnv_rises - r0, 1);
        check(valid_cnt - v0 == 1, "R7 strobes produced", valid_cnt - v0, 1);
        check(result == 14'h1234, "R7 result unaffected", result, 14'h1234);

        // R8: back-to-back with start held
        adc_next = 14'h2345;
        @(negedge clk); start = 1;
        while (!result_valid) @(negedge clk);
        gap = 0; adc_next = 14'h0777;
        do begin @(negedge clk); gap++; end while (!cnv && gap < 100);
        check(gap == TQ + 1, "R8 quiet gap", gap, TQ + 1);
        start = 0;
        while (!result_valid) @(negedge clk);
        check(result == 14'h0777, "R8 second word", result, 14'h0777);
        repeat (TQ + 2) @(negedge clk);

        // R1: reset in mid-read
        adc_next = 14'h3333;
        @(negedge clk); start = 1; @(negedge clk); start = 0;
        wait (sck == 1); @(negedge clk);
        rst_n = 0; @(negedge clk);
        check(cnv == 0 && sck == 0 && result == 0, "R1 mid-read reset", result, 0);
        rst_n = 1; repeat (3) @(negedge clk);
        check(cnv == 0 && result_valid == 0, "R1 idle after reset", cnv, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule